// File: doc/BRIEF.md
# Knockout Switch Output Port Interface

This block is the receive side of one output port in a fully connected packet switch. Every input of the switch drives a broadcast bus that carries a valid flag, a destination address and a payload. Each output port instance watches all of those buses at once. It keeps only the packets whose destination equals its own port address, which is set by a parameter.

In any one cycle up to N packets may target the same port. A concentrator keeps at most L of them, chosen by lowest input index, and discards the rest. The kept packets are spread across L small FIFOs in turn, so the FIFOs behave as one shared queue of L times DEPTH entries. The output side drains that queue one packet per cycle with a valid/ready handshake. Every discarded packet, whether it was knocked out by the concentrator or found no room in the buffer, adds one to a saturating loss counter.

Top module: `knockout_out_if`

## Requirements
- R1: After reset, out_valid_o is 0 and drop_cnt_o is 0.
- R2: A packet is taken only when its bus valid bit is 1 and its address field (bits i*ADDR_W upward of bus_addr_i) equals PORT_ADDR. Any other packet is neither stored nor counted as a loss.
- R3: When more than L_OUT packets match in one cycle, only the L_OUT with the lowest input indices are kept. Each excess packet adds 1 to drop_cnt_o.
- R4: Packets accepted in the same cycle leave in ascending input index. Packets accepted in different cycles leave in the order they arrived.
- R5: Stored packets are written across the FIFOs in rotating order. The buffer therefore holds exactly L_OUT*FIFO_DEPTH packets, however the arrivals were split across cycles.
- R6: Fullness is judged on the occupancy before the clock edge, so a pop in the same cycle frees no room. Once the buffer is full, the later survivors of that cycle (those with higher index) are dropped, and each one adds 1 to drop_cnt_o.
- R7: out_valid_o is 1 whenever the buffer holds a packet, and out_data_o shows the oldest one. While out_ready_i is 0, out_data_o stays stable. While out_ready_i is 1, one packet leaves on every cycle.
- R8: A packet presented before a clock edge to an empty buffer appears on out_data_o right after that edge. drop_cnt_o reflects losses from the same edge at which they occur, and it never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | N_IN | One valid bit per broadcast bus |
| bus_addr_i | input | N_IN*ADDR_W | Destination address for each bus, bus i in bits i*ADDR_W upward |
| bus_data_i | input | N_IN*DATA_W | Payload for each bus, bus i in bits i*DATA_W upward |
| out_ready_i | input | 1 | Downstream accepts the head packet |
| out_valid_o | output | 1 | Head packet available |
| out_data_o | output | DATA_W | Head packet payload |
| drop_cnt_o | output | CNT_W | Saturating count of lost packets |

## Verification
A packet driven on the buses before edge k becomes visible at out_data_o just after edge k. It leaves at the first later edge at which out_ready_i is 1. The loss counter moves at edge k itself.

All stimulus is applied on the falling edge. The bench model computes the expected queue and loss totals at that moment, using the occupancy as it stands before the coming rising edge. The output monitor samples one nanosecond before each rising edge and pops the expected queue only when a handshake is about to complete. Checks of the loss counter and of the empty state are made on a later falling edge, after the edges that commit them.

// File: rtl/ko_pkg.sv
package ko_pkg;
  localparam int unsigned KO_N_IN      = 8;
  localparam int unsigned KO_L_OUT     = 4;
  localparam int unsigned KO_ADDR_W    = 3;
  localparam int unsigned KO_DATA_W    = 32;
  localparam int unsigned KO_DEPTH     = 4;
  localparam int unsigned KO_CNT_W     = 16;
endpackage

// File: rtl/ko_filter.sv
module ko_filter #(
  parameter int unsigned N_IN      = 8,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned PORT_ADDR = 0
) (
  input  logic [N_IN-1:0]        bus_valid_i,
  input  logic [N_IN*ADDR_W-1:0] bus_addr_i,
  output logic [N_IN-1:0]        match_o
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(PORT_ADDR);

  for (genvar i = 0; i < N_IN; i++) begin : g_cmp
    assign match_o[i] = bus_valid_i[i] && (bus_addr_i[i*ADDR_W +: ADDR_W] == MY_ADDR);
  end
endmodule

// File: rtl/ko_conc.sv
module ko_conc #(
  parameter int unsigned N_IN   = 8,
  parameter int unsigned L_OUT  = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CW    = $clog2(N_IN + 1),
  localparam int unsigned LW    = $clog2(L_OUT)
) (
  input  logic [N_IN-1:0]         match_i,
  input  logic [N_IN*DATA_W-1:0]  bus_data_i,
  output logic [L_OUT-1:0]        slot_valid_o,
  output logic [L_OUT*DATA_W-1:0] slot_data_o,
  output logic [CW-1:0]           n_match_o
);
  // rank of each match = number of matches on lower inputs; rank >= L is knocked out
  always_comb begin
    logic [CW-1:0] rank;
    rank         = '0;
    slot_valid_o = '0;
    slot_data_o  = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (match_i[i]) begin
        if (rank < CW'(L_OUT)) begin
          slot_valid_o[rank[LW-1:0]] = 1'b1;
          slot_data_o[rank[LW-1:0]*DATA_W +: DATA_W] = bus_data_i[i*DATA_W +: DATA_W];
        end
        rank = rank + 1'b1;
      end
    end
    n_match_o = rank;
  end
endmodule

// File: rtl/ko_fifo.sv
module ko_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PW    = $clog2(DEPTH),
  localparam int unsigned OW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic              full_o,
  output logic              empty_o,
  output logic [DATA_W-1:0] head_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]     wp_q, rp_q;
  logic [OW-1:0]     occ_q;
  logic              do_push, do_pop;

  assign full_o  = (occ_q == OW'(DEPTH));
  assign empty_o = (occ_q == '0);
  assign head_o  = mem_q[rp_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      occ_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      occ_q <= occ_q + OW'(do_push) - OW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= push_data_i;
  end
endmodule

// File: rtl/ko_sbuf.sv
module ko_sbuf #(
  parameter int unsigned L_OUT  = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned CW     = 4,
  localparam int unsigned LW    = $clog2(L_OUT)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [L_OUT-1:0]        slot_valid_i,
  input  logic [L_OUT*DATA_W-1:0] slot_data_i,
  input  logic                    pop_i,
  output logic                    head_valid_o,
  output logic [DATA_W-1:0]       head_data_o,
  output logic [CW-1:0]           n_written_o
);
  logic [LW-1:0]     wsel_q, rsel_q;
  logic [L_OUT-1:0]  push, pop, full, empty;
  logic [DATA_W-1:0] pdata [L_OUT];
  logic [DATA_W-1:0] head  [L_OUT];
  logic              pop_fire;

  // slot j goes to FIFO wsel+j; the first full target stops the rest of the cycle
  always_comb begin
    logic          ok;
    logic [LW-1:0] tgt;
    ok          = 1'b1;
    push        = '0;
    n_written_o = '0;
    for (int f = 0; f < L_OUT; f++) pdata[f] = '0;
    for (int j = 0; j < L_OUT; j++) begin
      tgt = wsel_q + LW'(j);
      if (ok && slot_valid_i[j] && !full[tgt]) begin
        push[tgt]   = 1'b1;
        pdata[tgt]  = slot_data_i[j*DATA_W +: DATA_W];
        n_written_o = n_written_o + 1'b1;
      end else begin
        ok = 1'b0;
      end
    end
  end

  assign head_valid_o = !empty[rsel_q];
  assign head_data_o  = head[rsel_q];
  assign pop_fire     = head_valid_o && pop_i;

  for (genvar f = 0; f < L_OUT; f++) begin : g_fifo
    assign pop[f] = pop_fire && (rsel_q == LW'(f));
    ko_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (push[f]),
      .push_data_i (pdata[f]),
      .pop_i       (pop[f]),
      .full_o      (full[f]),
      .empty_o     (empty[f]),
      .head_o      (head[f])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wsel_q <= '0;
      rsel_q <= '0;
    end else begin
      wsel_q <= wsel_q + LW'(n_written_o);
      if (pop_fire) rsel_q <= rsel_q + 1'b1;
    end
  end
endmodule

// File: rtl/knockout_out_if.sv
module knockout_out_if
  import ko_pkg::*;
#(
  parameter int unsigned N_IN       = KO_N_IN,
  parameter int unsigned L_OUT      = KO_L_OUT,   // power of two, >= 2, <= N_IN
  parameter int unsigned ADDR_W     = KO_ADDR_W,
  parameter int unsigned DATA_W     = KO_DATA_W,
  parameter int unsigned FIFO_DEPTH = KO_DEPTH,   // power of two, >= 2
  parameter int unsigned CNT_W      = KO_CNT_W,
  parameter int unsigned PORT_ADDR  = 0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_IN-1:0]          bus_valid_i,
  input  logic [N_IN*ADDR_W-1:0]   bus_addr_i,
  input  logic [N_IN*DATA_W-1:0]   bus_data_i,
  input  logic                     out_ready_i,
  output logic                     out_valid_o,
  output logic [DATA_W-1:0]        out_data_o,
  output logic [CNT_W-1:0]         drop_cnt_o
);
  localparam int unsigned CW = $clog2(N_IN + 1);

  logic [N_IN-1:0]         match;
  logic [L_OUT-1:0]        slot_valid;
  logic [L_OUT*DATA_W-1:0] slot_data;
  logic [CW-1:0]           n_match, n_written, n_drop;
  logic [CNT_W:0]          drop_sum;

  ko_filter #(.N_IN(N_IN), .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_filter (
    .bus_valid_i (bus_valid_i),
    .bus_addr_i  (bus_addr_i),
    .match_o     (match)
  );

  ko_conc #(.N_IN(N_IN), .L_OUT(L_OUT), .DATA_W(DATA_W)) u_conc (
    .match_i      (match),
    .bus_data_i   (bus_data_i),
    .slot_valid_o (slot_valid),
    .slot_data_o  (slot_data),
    .n_match_o    (n_match)
  );

  ko_sbuf #(.L_OUT(L_OUT), .DATA_W(DATA_W), .DEPTH(FIFO_DEPTH), .CW(CW)) u_sbuf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slot_valid_i (slot_valid),
    .slot_data_i  (slot_data),
    .pop_i        (out_ready_i),
    .head_valid_o (out_valid_o),
    .head_data_o  (out_data_o),
    .n_written_o  (n_written)
  );

  // knocked out plus refused by a full buffer
  assign n_drop   = n_match - n_written;
  assign drop_sum = {1'b0, drop_cnt_o} + (CNT_W + 1)'(n_drop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             drop_cnt_o <= '0;
    else if (drop_sum[CNT_W]) drop_cnt_o <= '1;
    else                     drop_cnt_o <= drop_sum[CNT_W-1:0];
  end
endmodule

// File: rtl/ko_chk.sv
module ko_chk #(
  parameter int unsigned N_IN      = 8,
  parameter int unsigned L_OUT     = 4,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PORT_ADDR = 0
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_IN-1:0]        bus_valid_i,
  input logic [N_IN*ADDR_W-1:0] bus_addr_i,
  input logic                   out_ready_i,
  input logic                   out_valid_o,
  input logic [DATA_W-1:0]      out_data_o,
  input logic [CNT_W-1:0]       drop_cnt_o
);
  int unsigned hits;
  always_comb begin
    hits = 0;
    for (int i = 0; i < N_IN; i++)
      if (bus_valid_i[i] && bus_addr_i[i*ADDR_W +: ADDR_W] == ADDR_W'(PORT_ADDR)) hits++;
  end

  // R8
  drop_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> drop_cnt_o >= $past(drop_cnt_o));

  // R2
  drop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hits == 0 |=> $stable(drop_cnt_o));

  // R3
  knock_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hits > L_OUT) && (drop_cnt_o != '1) |=> drop_cnt_o != $past(drop_cnt_o));

  // R7
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));
endmodule

bind knockout_out_if ko_chk #(
  .N_IN(N_IN), .L_OUT(L_OUT), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .CNT_W(CNT_W), .PORT_ADDR(PORT_ADDR)
) u_chk (.*);

// File: tb/sim_knockout_out_if.sv
`timescale 1ns/1ps
module sim_knockout_out_if;
  localparam int N = 8, L = 4, AW = 3, DW = 32, DEPTH = 4, CW = 16, ME = 5;
  localparam int CAP = L * DEPTH;

  logic clk = 0, rst_n = 0, rdy = 0;
  logic [N-1:0]    bv = '0;
  logic [N*AW-1:0] ba = '0;
  logic [N*DW-1:0] bd = '0;
  logic            ov;
  logic [DW-1:0]   od;
  logic [CW-1:0]   dc;

  int tests = 0, fails = 0, exp_drop = 0, tag = 0;
  logic [DW-1:0] q[$];
  bit run_mon = 0;

  always #2 clk = ~clk;

  knockout_out_if #(.N_IN(N), .L_OUT(L), .ADDR_W(AW), .DATA_W(DW),
                    .FIFO_DEPTH(DEPTH), .CNT_W(CW), .PORT_ADDR(ME)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(bv), .bus_addr_i(ba), .bus_data_i(bd),
    .out_ready_i(rdy), .out_valid_o(ov), .out_data_o(od), .drop_cnt_o(dc));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N*AW-1:0] mk_addr(input logic [N-1:0] m);
    logic [N*AW-1:0] a;
    for (int i = 0; i < N; i++) a[i*AW +: AW] = m[i] ? AW'(ME) : AW'((ME + 1 + i) % 8 == ME ? 0 : (ME + 1 + i) % 8);
    return a;
  endfunction

  // driver: apply one cycle of bus traffic and push expected survivors
  task automatic step(input logic [N-1:0] v, input logic [N*AW-1:0] a, input bit r);
    int kept;
    @(negedge clk);
    tag++;
    bv = v; ba = a; rdy = r;
    kept = 0;
    for (int i = 0; i < N; i++) begin
      bd[i*DW +: DW] = DW'(32'hA000_0000 | (tag << 8) | i);
      if (v[i] && a[i*AW +: AW] == AW'(ME)) begin
        if (kept < L && q.size() < CAP) q.push_back(bd[i*DW +: DW]);
        else exp_drop++;
        kept++;
      end
    end
  endtask

  task automatic idle(input bit r);
    step('0, '0, r);
  endtask

  // monitor: sample just before each rising edge
  initial forever begin
    @(negedge clk);
    #1;
    if (run_mon) begin
      if (ov && q.size() == 0) chk(0, "R7 spurious valid", ov, 0);
      else if (ov && rdy) begin
        logic [DW-1:0] e;
        e = q.pop_front();
        chk(od == e, "R4 order", od, e);
      end
    end
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ov == 0, "R1 valid", ov, 0);
    chk(dc == 0, "R1 drop", dc, 0);
    run_mon = 1;

    // R8 latency into empty buffer
    step(8'b0000_1000, mk_addr(8'hFF), 0);
    @(posedge clk); #1;
    chk(ov == 1, "R8 valid after edge", ov, 1);
    chk(od == q[0], "R8 data after edge", od, q[0]);
    repeat (3) idle(1);

    // R2 nothing for another address
    step(8'hFF, mk_addr(8'h00), 1);
    step(8'h00, mk_addr(8'hFF), 1);
    idle(1); idle(1);
    chk(ov == 0, "R2 nothing stored", ov, 0);
    chk(dc == 0, "R2 no loss", dc, 0);

    // R4 ascending order within a cycle
    step(8'hFF, mk_addr(8'b0101_0010), 0);
    idle(0);
    chk(q.size() == 3, "R4 expected count", q.size(), 3);
    repeat (4) idle(1);
    chk(ov == 0, "R4 drained", ov, 0);

    // R3 six matches, four kept
    step(8'hFF, mk_addr(8'b1110_1101), 1);
    idle(1);
    chk(dc == 2, "R3 knocked out", dc, 2);
    repeat (5) idle(1);

    // R5 R6 fill with 3-packet cycles, no draining
    for (int k = 0; k < 6; k++) step(8'hFF, mk_addr(8'b0000_0111), 0);
    idle(0);
    chk(dc == 4, "R6 full drops", dc, 4);
    chk(q.size() == CAP, "R5 capacity", q.size(), CAP);
    held = od;
    idle(0); idle(0);
    chk(ov == 1 && od == held, "R7 stable while stalled", od, held);
    // R6 pop in same cycle frees no room
    step(8'hFF, mk_addr(8'b0000_0001), 1);
    idle(0);
    chk(dc == 5, "R6 pop same cycle", dc, 5);
    for (int k = 0; k < CAP - 1; k++) idle(1);
    @(negedge clk);
    chk(ov == 0, "R7 one per cycle drain", ov, 0);
    chk(q.size() == 0, "R7 model empty", q.size(), 0);

    // mixed traffic with a pseudo-random ready
    begin
      logic [15:0] lf = 16'hACE1;
      for (int k = 0; k < 300; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        step(lf[7:0], mk_addr(lf[15:8]), lf[3] | lf[9]);
      end
    end
    idle(1);
    chk(dc == CW'(exp_drop), "R3 R6 total losses", dc, exp_drop);
    repeat (CAP + 2) idle(1);
    @(negedge clk);
    chk(ov == 0 && q.size() == 0, "R7 final drain", q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule